// File: doc/BRIEF.md
# Sample-Period Sequencing Controller

This block is the major state machine of a sampled filtering datapath. Once per sampling period it receives a single-cycle sample tick and runs a fixed chain of phases. First it writes the result of the previous period's convolution to the D/A converter over a shared data bus. Next it stores the A/D word captured in the previous period into sample memory. It then starts a fresh A/D conversion, so the converter works while the arithmetic runs. After that it launches the convolution engine and waits for it to finish. Last, it reads the finished conversion back off the shared bus and returns to idle.

Every converter control line is the output of a flip-flop. The bus direction control is also registered, so the controller and the A/D converter never drive the bus in the same cycle, and a dead cycle separates any change of bus owner. After reset the controller spends a fixed number of cycles in an initialization phase before it accepts sample ticks. A tick that arrives while the controller is not idle is dropped and recorded in a sticky overrun flag.

Top module: `sample_seq_ctrl`

## Requirements
- R1: While reset is held and after it is released, all converter strobes are inactive (both chip-selects and enables high, adc_rw high), and bus_oe, mem_we, conv_start and overrun are low. The controller stays in initialization for INIT_CYCLES clock edges after reset release. A tick sampled on edge INIT_CYCLES+1 or later is accepted.
- R2: On the edge that samples a tick while idle, dac_cs_n goes low and bus_oe goes high, with bus_out equal to the last accepted convolution result (0 after reset). On the next edge dac_ce_n goes low for exactly one cycle. dac_cs_n and bus_oe stay asserted for three cycles in total, then both release together.
- R3: On the fifth edge after the tick, mem_we is high for one cycle and mem_wdata equals the A/D word captured in the previous period (0 after reset).
- R4: On the sixth edge after the tick, adc_cs_n, adc_ce_n and adc_rw are all low for one cycle, which starts a conversion. On the seventh edge all three return high.
- R5: On the eighth edge after the tick, conv_start is high for exactly one cycle. This pulse follows the conversion start.
- R6: After conv_start the controller waits with no converter activity for as long as conv_done stays low. The edge that samples conv_done high latches conv_result and begins the read: one cycle with adc_cs_n low and adc_rw high, then one cycle with adc_ce_n also low. bus_in is captured on the edge that ends the enable cycle. Then all strobes release and the controller is idle again.
- R7: The A/D converter is never read (adc_cs_n low, adc_ce_n low, adc_rw high) while bus_oe is high or in the cycle right after bus_oe was high.
- R8: A tick sampled while the controller is not idle (including initialization) sets overrun, which stays high until reset, and does not restart the sequence.
- R9: conv_done sampled while the controller is not waiting for the engine is ignored: no read is started and the stored result is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_tick | input | 1 | One-cycle tick marking the start of a sampling period |
| conv_start | output | 1 | One-cycle launch pulse to the convolution engine |
| conv_done | input | 1 | Completion pulse from the convolution engine |
| conv_result | input | W | Output sample produced by the convolution engine |
| dac_cs_n | output | 1 | D/A chip-select, active low |
| dac_ce_n | output | 1 | D/A enable/latch strobe, active low |
| adc_cs_n | output | 1 | A/D chip-select, active low |
| adc_ce_n | output | 1 | A/D enable, active low |
| adc_rw | output | 1 | A/D direction: 0 starts a conversion, 1 reads the result |
| bus_oe | output | 1 | Controller drives the shared bus when high |
| bus_out | output | W | Word driven onto the shared bus |
| bus_in | input | W | Word seen on the shared bus |
| mem_we | output | 1 | Sample memory write strobe |
| mem_wdata | output | W | Word written into sample memory |
| overrun | output | 1 | Sticky flag: a tick arrived while busy |

## Verification
The bench steps through whole sampling periods and checks every strobe on each cycle. A controller that reorders the phases or stretches a strobe by one cycle is caught by these per-cycle checks. Different engine latencies, including zero, expose a design that reads the converter too early or treats a late done pulse wrongly. A bus monitor flags any cycle where the converter could drive the bus alongside the controller or right after it. The bench also sends stray done pulses while the controller is idle and ticks while it is busy or initializing. A design that latched the stray result, restarted on a busy tick, or failed to hold the overrun flag would show a wrong D/A word in the next period or a low overrun flag.

// File: rtl/ssc_pkg.sv
package ssc_pkg;

  typedef enum logic [3:0] {
    S_INIT, S_WAIT, S_DAC_SETUP, S_DAC_WRITE, S_DAC_HOLD, S_TURN,
    S_STORE, S_ADC_START, S_ADC_END, S_CONV, S_CONV_WAIT,
    S_RD_SETUP, S_RD_EN, S_RD_END
  } phase_t;

  typedef struct packed {
    logic dac_cs_n;
    logic dac_ce_n;
    logic adc_cs_n;
    logic adc_ce_n;
    logic adc_rw;
    logic bus_oe;
    logic mem_we;
    logic conv_start;
  } ctl_t;

  // Control word that each phase holds on the pins.
  function automatic ctl_t phase_controls(phase_t p);
    ctl_t c;
    c = '{dac_cs_n: 1'b1, dac_ce_n: 1'b1, adc_cs_n: 1'b1, adc_ce_n: 1'b1,
          adc_rw: 1'b1, bus_oe: 1'b0, mem_we: 1'b0, conv_start: 1'b0};
    case (p)
      S_DAC_SETUP, S_DAC_HOLD: begin
        c.dac_cs_n = 1'b0;
        c.bus_oe   = 1'b1;
      end
      S_DAC_WRITE: begin
        c.dac_cs_n = 1'b0;
        c.dac_ce_n = 1'b0;
        c.bus_oe   = 1'b1;
      end
      S_STORE:     c.mem_we = 1'b1;
      S_ADC_START: begin
        c.adc_cs_n = 1'b0;
        c.adc_ce_n = 1'b0;
        c.adc_rw   = 1'b0;
      end
      S_CONV:      c.conv_start = 1'b1;
      S_RD_SETUP:  c.adc_cs_n = 1'b0;
      S_RD_EN: begin
        c.adc_cs_n = 1'b0;
        c.adc_ce_n = 1'b0;
      end
      default: ;
    endcase
    return c;
  endfunction

  // Phase order within one sampling period.
  function automatic phase_t next_phase(phase_t p, logic tick, logic init_done,
                                        logic done);
    case (p)
      S_INIT:      return init_done ? S_WAIT : S_INIT;
      S_WAIT:      return tick ? S_DAC_SETUP : S_WAIT;
      S_DAC_SETUP: return S_DAC_WRITE;
      S_DAC_WRITE: return S_DAC_HOLD;
      S_DAC_HOLD:  return S_TURN;
      S_TURN:      return S_STORE;
      S_STORE:     return S_ADC_START;
      S_ADC_START: return S_ADC_END;
      S_ADC_END:   return S_CONV;
      S_CONV:      return S_CONV_WAIT;
      S_CONV_WAIT: return done ? S_RD_SETUP : S_CONV_WAIT;
      S_RD_SETUP:  return S_RD_EN;
      S_RD_EN:     return S_RD_END;
      S_RD_END:    return S_WAIT;
      default:     return S_INIT;
    endcase
  endfunction

endpackage

// File: rtl/ssc_init_timer.sv
module ssc_init_timer #(
  parameter int INIT_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  output logic expired
);
  localparam int CW = $clog2(INIT_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(INIT_CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt <= '0;
    else if (active && cnt != LAST)  cnt <= cnt + 1'b1;
  end

  assign expired = active && (cnt == LAST);

  initial assert (INIT_CYCLES >= 1) else $error("INIT_CYCLES must be at least 1");
endmodule

// File: rtl/ssc_phase_fsm.sv
module ssc_phase_fsm
  import ssc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   sample_tick,
  input  logic   init_done,
  input  logic   conv_done,
  output phase_t phase,
  output phase_t phase_n,
  output logic   in_wait,
  output logic   in_init
);
  assign phase_n = next_phase(phase, sample_tick, init_done, conv_done);
  assign in_wait = (phase == S_WAIT);
  assign in_init = (phase == S_INIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= S_INIT;
    else        phase <= phase_n;
  end

  // R6: while the engine is busy the controller holds its place
  assert_hold_for_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == S_CONV_WAIT && !conv_done) |=> (phase == S_CONV_WAIT));
endmodule

// File: rtl/ssc_io_regs.sv
module ssc_io_regs
  import ssc_pkg::*;
#(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  phase_t       phase,
  input  phase_t       phase_n,
  input  logic         in_wait,
  input  logic         sample_tick,
  input  logic         conv_done,
  input  logic [W-1:0] conv_result,
  input  logic [W-1:0] bus_in,
  output ctl_t         ctl_q,
  output logic [W-1:0] bus_word,
  output logic [W-1:0] store_word,
  output logic         overrun
);
  logic [W-1:0] result_q;
  logic         take_result;
  logic         take_sample;
  logic         load_bus;
  logic         adc_reading;

  assign take_result = (phase == S_CONV_WAIT) && conv_done;
  assign take_sample = (phase == S_RD_EN);
  assign load_bus    = (phase_n == S_DAC_SETUP) && (phase != S_DAC_SETUP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q      <= phase_controls(S_INIT);
      result_q   <= '0;
      store_word <= '0;
      bus_word   <= '0;
      overrun    <= 1'b0;
    end else begin
      ctl_q <= phase_controls(phase_n);
      if (take_result) result_q   <= conv_result;
      if (take_sample) store_word <= bus_in;
      if (load_bus)    bus_word   <= result_q;
      if (sample_tick && !in_wait) overrun <= 1'b1;
    end
  end

  assign adc_reading = !ctl_q.adc_cs_n && !ctl_q.adc_ce_n && ctl_q.adc_rw;

  assert_dac_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_q.dac_ce_n |-> (!ctl_q.dac_cs_n && ctl_q.bus_oe));
  assert_dac_strobe_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_q.dac_ce_n |=> ctl_q.dac_ce_n);
  assert_store_after_dac_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q.mem_we |-> ($past(ctl_q.bus_oe, 2) && !ctl_q.bus_oe));
  assert_adc_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_q.adc_ce_n && !ctl_q.adc_rw) |=> (ctl_q.adc_ce_n && ctl_q.adc_cs_n));
  assert_start_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q.conv_start |=> !ctl_q.conv_start);
  assert_bus_turn_R7: assert property (@(posedge clk) disable iff (!rst_n)
    adc_reading |-> (!ctl_q.bus_oe && !$past(ctl_q.bus_oe)));
  assert_overrun_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_tick && !in_wait) |=> overrun);
  assert_overrun_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);
endmodule

// File: rtl/sample_seq_ctrl.sv
module sample_seq_ctrl
  import ssc_pkg::*;
#(
  parameter int W           = 12,
  parameter int INIT_CYCLES = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sample_tick,
  output logic         conv_start,
  input  logic         conv_done,
  input  logic [W-1:0] conv_result,
  output logic         dac_cs_n,
  output logic         dac_ce_n,
  output logic         adc_cs_n,
  output logic         adc_ce_n,
  output logic         adc_rw,
  output logic         bus_oe,
  output logic [W-1:0] bus_out,
  input  logic [W-1:0] bus_in,
  output logic         mem_we,
  output logic [W-1:0] mem_wdata,
  output logic         overrun
);
  phase_t phase;
  phase_t phase_n;
  logic   in_wait;
  logic   in_init;
  logic   init_done;
  ctl_t   ctl_q;

  ssc_init_timer #(.INIT_CYCLES(INIT_CYCLES)) u_init (
    .clk(clk), .rst_n(rst_n), .active(in_init), .expired(init_done)
  );

  ssc_phase_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick),
    .init_done(init_done), .conv_done(conv_done),
    .phase(phase), .phase_n(phase_n), .in_wait(in_wait), .in_init(in_init)
  );

  ssc_io_regs #(.W(W)) u_io (
    .clk(clk), .rst_n(rst_n), .phase(phase), .phase_n(phase_n),
    .in_wait(in_wait), .sample_tick(sample_tick), .conv_done(conv_done),
    .conv_result(conv_result), .bus_in(bus_in), .ctl_q(ctl_q),
    .bus_word(bus_out), .store_word(mem_wdata), .overrun(overrun)
  );

  assign dac_cs_n   = ctl_q.dac_cs_n;
  assign dac_ce_n   = ctl_q.dac_ce_n;
  assign adc_cs_n   = ctl_q.adc_cs_n;
  assign adc_ce_n   = ctl_q.adc_ce_n;
  assign adc_rw     = ctl_q.adc_rw;
  assign bus_oe     = ctl_q.bus_oe;
  assign mem_we     = ctl_q.mem_we;
  assign conv_start = ctl_q.conv_start;

  // R1: nothing is driven during initialization
  assert_init_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_init |-> (dac_cs_n && adc_cs_n && !bus_oe && !mem_we && !conv_start));
  // R9: a done pulse outside the engine wait starts no read
  assert_stray_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && in_wait && !sample_tick) |=> (adc_cs_n && in_wait));
endmodule

// File: tb/sample_seq_ctrl_bench.sv
module sample_seq_ctrl_bench;
  localparam int W    = 12;
  localparam int INIT = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sample_tick = 1'b0;
  logic conv_done = 1'b0;
  logic [W-1:0] conv_result = '0;
  logic [W-1:0] bus_in = '0;
  logic conv_start, dac_cs_n, dac_ce_n, adc_cs_n, adc_ce_n, adc_rw;
  logic bus_oe, mem_we, overrun;
  logic [W-1:0] bus_out, mem_wdata;

  int tests = 0;
  int fails = 0;
  int bus_viol = 0;
  logic prev_oe = 1'b0;
  logic [W-1:0] prev_result = '0;
  logic [W-1:0] prev_adc = '0;

  always #2 clk = ~clk;

  sample_seq_ctrl #(.W(W), .INIT_CYCLES(INIT)) u_sample_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick),
    .conv_start(conv_start), .conv_done(conv_done), .conv_result(conv_result),
    .dac_cs_n(dac_cs_n), .dac_ce_n(dac_ce_n), .adc_cs_n(adc_cs_n),
    .adc_ce_n(adc_ce_n), .adc_rw(adc_rw), .bus_oe(bus_oe), .bus_out(bus_out),
    .bus_in(bus_in), .mem_we(mem_we), .mem_wdata(mem_wdata), .overrun(overrun)
  );

  // R7 monitor: converter read overlapping or touching a controller drive
  always @(negedge clk) begin
    if (rst_n && !adc_cs_n && !adc_ce_n && adc_rw && (bus_oe || prev_oe))
      bus_viol++;
    prev_oe = bus_oe;
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; sample_tick = 1'b0; conv_done = 1'b0; bus_in = '0;
    repeat (3) @(negedge clk);
    chk("R1", "strobes in reset", {dac_cs_n, dac_ce_n, adc_cs_n, adc_ce_n, adc_rw}, 5'b11111);
    chk("R1", "drives in reset", {bus_oe, mem_we, conv_start, overrun}, 4'b0000);
    rst_n = 1'b1;
    prev_result = '0; prev_adc = '0;
  endtask

  // One full period; busy_tick injects a tick while waiting for the engine.
  task automatic run_period(logic [W-1:0] result, logic [W-1:0] adcval,
                            int done_delay, bit busy_tick);
    int quiet = 0;
    @(negedge clk) sample_tick = 1'b1;
    @(negedge clk) sample_tick = 1'b0;
    chk("R2", "c1 dac cs/oe/ce", {dac_cs_n, bus_oe, dac_ce_n}, 3'b011);
    chk("R2", "c1 bus_out", bus_out, prev_result);
    @(negedge clk);
    chk("R2", "c2 dac cs/oe/ce", {dac_cs_n, bus_oe, dac_ce_n}, 3'b010);
    @(negedge clk);
    chk("R2", "c3 dac cs/oe/ce", {dac_cs_n, bus_oe, dac_ce_n}, 3'b011);
    @(negedge clk);
    chk("R2", "c4 release", {dac_cs_n, bus_oe, mem_we}, 3'b100);
    @(negedge clk);
    chk("R3", "c5 mem_we", mem_we, 1'b1);
    chk("R3", "c5 mem_wdata", mem_wdata, prev_adc);
    @(negedge clk);
    chk("R4", "c6 adc start", {adc_cs_n, adc_ce_n, adc_rw, mem_we}, 4'b0000);
    @(negedge clk);
    chk("R4", "c7 adc end", {adc_cs_n, adc_ce_n, adc_rw}, 3'b111);
    chk("R5", "c7 no start yet", conv_start, 1'b0);
    @(negedge clk);
    chk("R5", "c8 conv_start", conv_start, 1'b1);
    @(negedge clk);
    chk("R5", "c9 conv_start low", conv_start, 1'b0);
    for (int i = 0; i < done_delay; i++) begin
      if (busy_tick && i == 0) sample_tick = 1'b1;
      @(negedge clk);
      if (busy_tick && i == 0) begin
        sample_tick = 1'b0;
        chk("R8", "overrun on busy tick", overrun, 1'b1);
      end
      if (!adc_cs_n || !dac_cs_n || conv_start) quiet++;
    end
    chk("R6", "quiet while engine busy", quiet, 0);
    conv_result = result; conv_done = 1'b1;
    @(negedge clk) conv_done = 1'b0;
    conv_result = ~result;
    chk("R6", "read setup", {adc_cs_n, adc_ce_n, adc_rw}, 3'b011);
    bus_in = adcval;
    @(negedge clk);
    chk("R6", "read enable", {adc_cs_n, adc_ce_n, adc_rw}, 3'b001);
    @(negedge clk);
    bus_in = ~adcval;
    chk("R6", "read end", {adc_cs_n, adc_ce_n}, 2'b11);
    @(negedge clk);
    prev_result = result; prev_adc = adcval;
  endtask

  task automatic t_init_accept();
    repeat (INIT) @(negedge clk);
    chk("R1", "quiet during init", {dac_cs_n, bus_oe}, 2'b10);
    run_period(12'h5A3, 12'h1C7, 0, 1'b0);
    chk("R1", "tick after init accepted without overrun", overrun, 1'b0);
  endtask

  task automatic t_patterns();
    run_period(12'hFFF, 12'h000, 1, 1'b0);
    run_period(12'h001, 12'hFFF, 7, 1'b0);
    run_period(12'h800, 12'h7FF, 30, 1'b0);
    run_period(12'h123, 12'h456, 0, 1'b0);
    chk("R7", "bus owner overlap count", bus_viol, 0);
  endtask

  task automatic t_stray_done();
    conv_result = 12'hBAD; conv_done = 1'b1;
    @(negedge clk) conv_done = 1'b0;
    chk("R9", "no read on stray done", adc_cs_n, 1'b1);
    @(negedge clk);
    chk("R9", "still idle", {adc_cs_n, dac_cs_n}, 2'b11);
    run_period(12'h321, 12'h654, 2, 1'b0);
  endtask

  task automatic t_busy_tick();
    run_period(12'h0F0, 12'h0AB, 4, 1'b1);
    chk("R8", "overrun sticky", overrun, 1'b1);
    run_period(12'h00F, 12'hCDE, 1, 1'b0);
    chk("R8", "overrun still set", overrun, 1'b1);
  endtask

  task automatic t_init_tick();
    do_reset();
    chk("R1", "overrun cleared by reset", overrun, 1'b0);
    repeat (INIT - 1) @(negedge clk);
    sample_tick = 1'b1;
    @(negedge clk) sample_tick = 1'b0;
    chk("R8", "tick in init flags overrun", overrun, 1'b1);
    chk("R8", "tick in init ignored", {dac_cs_n, bus_oe}, 2'b10);
    @(negedge clk);
    chk("R8", "no late start", dac_cs_n, 1'b1);
  endtask

  initial begin
    do_reset();
    t_init_accept();
    t_patterns();
    t_stray_done();
    t_busy_tick();
    t_init_tick();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule